// File: doc/BRIEF.md
# Tagged Conversion Result FIFO

This block collects the results of a group of converters that all finish together. Each conversion cycle delivers one result per converter along with a channel tag. The block stores the results as 16-bit words, with the tag in the top nibble and the 12-bit two's-complement result below it. Words are written in fixed converter order, one per clock. A host then drains the words one at a time through a single read strobe.

The buffer is a circular store of 32 words. Reading it while it holds nothing does not underflow: the last word returned is presented again, and an empty event is recorded. Writing into a buffer that already holds 32 unread words overwrites the oldest word and records a full event. Each of these events has two forms. The level form is cleared by the opposite traffic. The sticky form holds until the host pulses a status read.

A data-available output with programmable active level tells the host that words are waiting. An interrupt line combines the enabled sticky flags with external counter flags. A synchronous clear empties the store.

Top module: `conv_fifo`

## Requirements
- R1: The store holds up to 32 unread words and returns them oldest first. Each word carries the converter's tag in bits 15:12 and its 12-bit result in bits 11:0.
- R2: A `conv_valid` pulse writes converter 0's word on that clock edge, converter 1's on the next and converter 2's on the one after. Converter i's tag is `conv_tag[4i+3:4i]` and its result is `conv_res[12i+11:12i]`. `conv_valid` must not recur while words are still pending.
- R3: `dav` is registered. It equals `dav_pol` while unread words exist and `~dav_pol` when none remain.
- R4: A read strobe on a non-empty store loads the oldest unread word into `rd_data` at that edge and consumes it.
- R5: A read strobe on an empty store leaves `rd_data` unchanged, consumes nothing and sets `lvl_empty`.
- R6: Any write clears `lvl_empty`, and a write takes priority over an empty read in the same cycle.
- R7: A write that finds 32 unread words, with no read in the same cycle, drops the oldest word, keeps 32 words and sets `lvl_full`. The next read strobe clears `lvl_full`.
- R8: `stk_full` and `stk_empty` are set by the same events as their level forms. They stay set until a `stat_rd` pulse. If a new event and `stat_rd` occur together, the flag stays set.
- R9: `irq` is registered and is the OR of the enabled sources. `irq_en` bit 0 enables `stk_full`, bit 1 enables `stk_empty`, bit 2 enables `cnt_flags[0]` and bit 3 enables `cnt_flags[1]`. The sticky values used are the ones being written at that edge.
- R10: `clr` empties the store, drops pending converter words and clears all four flags. `rd_data` is kept.
- R11: After reset, `rd_data` is 0, all flags and `irq` are 0, and `dav` is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of store and flags |
| conv_valid | input | 1 | One conversion cycle's results are present |
| conv_tag | input | 12 | Channel tags, converter i at bits 4i+3:4i |
| conv_res | input | 36 | Results, converter i at bits 12i+11:12i |
| rd_en | input | 1 | Host read of the data word |
| stat_rd | input | 1 | Host read of status, clears sticky flags |
| dav_pol | input | 1 | Active level of `dav` |
| irq_en | input | 4 | Interrupt source enables |
| cnt_flags | input | 2 | External counter overflow/underflow flags |
| rd_data | output | 16 | Last word read |
| dav | output | 1 | Data available, polarity per `dav_pol` |
| lvl_full | output | 1 | Overflow level state |
| lvl_empty | output | 1 | Empty-read level state |
| stk_full | output | 1 | Sticky overflow flag |
| stk_empty | output | 1 | Sticky empty-read flag |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the block with its default parameters: 32 words, three converters and two counter flags. With those values, twelve back-to-back conversion cycles with no reads put the buffer into overwrite, and a long random phase wraps both pointers many times. The three-converter width also lets a clear land between the first and last word of a conversion cycle, and lets an empty read coincide with a pending write.

// File: rtl/conv_fifo_pkg.sv
package conv_fifo_pkg;

  // Per-cycle traffic events produced by the storage and consumed by the flags
  typedef struct packed {
    logic wr;    // a word is written
    logic take;  // a read consumes a word
    logic dry;   // a read found nothing to consume
    logic ovf;   // a write overwrote the oldest word
  } fifo_evt_t;

endpackage

// File: rtl/cf_serializer.sv
module cf_serializer #(
  parameter int NUM_CONV = 3,
  parameter int TAG_W    = 4,
  parameter int RES_W    = 12,
  localparam int WORD_W  = TAG_W + RES_W,
  localparam int IW      = (NUM_CONV > 1) ? $clog2(NUM_CONV) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      conv_valid,
  input  logic [NUM_CONV*TAG_W-1:0] conv_tag,
  input  logic [NUM_CONV*RES_W-1:0] conv_res,
  output logic                      wr_en,
  output logic [WORD_W-1:0]         wr_word
);

  logic [WORD_W-1:0] words [NUM_CONV];
  logic [WORD_W-1:0] hold  [NUM_CONV];
  logic [IW-1:0]     idx;
  logic              busy;

  for (genvar i = 0; i < NUM_CONV; i++) begin : g_pack
    assign words[i] = {conv_tag[i*TAG_W +: TAG_W], conv_res[i*RES_W +: RES_W]};
  end

  assign busy    = (idx != '0);
  assign wr_en   = conv_valid || busy;
  assign wr_word = conv_valid ? words[0] : hold[idx];

  always_ff @(posedge clk) begin
    if (conv_valid) begin
      for (int i = 0; i < NUM_CONV; i++) hold[i] <= words[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx <= '0;
    end else if (conv_valid) begin
      idx <= (NUM_CONV > 1) ? IW'(1) : '0;
    end else if (busy) begin
      idx <= (idx == IW'(NUM_CONV - 1)) ? '0 : idx + IW'(1);
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    conv_valid |-> !busy); // R2

endmodule

// File: rtl/cf_store.sv
module cf_store
  import conv_fifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              nonempty_n,
  output fifo_evt_t         evt
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [CW-1:0]     count, count_n;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    evt.wr   = wr_en && !clr;
    evt.take = rd_en && !clr && (count != '0);
    evt.dry  = rd_en && !clr && (count == '0);
    evt.ovf  = evt.wr && !rd_en && (count == CW'(DEPTH));
    count_n  = count;
    if (clr)                      count_n = '0;
    else if (evt.wr && !evt.ovf && !evt.take) count_n = count + CW'(1);
    else if (evt.take && !evt.wr) count_n = count - CW'(1);
  end

  assign nonempty_n = (count_n != '0);

  // storage array: write port only, no reset, read-before-write
  always_ff @(posedge clk) begin
    if (evt.wr) mem[wp] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (evt.take) begin
      rd_data <= mem[rp];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (evt.wr)              wp <= bump(wp);
      if (evt.take || evt.ovf) rp <= bump(rp);
      count <= count_n;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R1

  AST_DRY_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
    evt.dry |=> $stable(rd_data)); // R5

  AST_OVF_STAYS_FULL: assert property (@(posedge clk) disable iff (rst)
    evt.ovf |=> (count == CW'(DEPTH))); // R7

endmodule

// File: rtl/cf_flags.sv
module cf_flags
  import conv_fifo_pkg::*;
#(
  parameter int NUM_CNT = 2,
  localparam int NSRC   = NUM_CNT + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  fifo_evt_t          evt,
  input  logic               nonempty_n,
  input  logic               stat_rd,
  input  logic               dav_pol,
  input  logic [NSRC-1:0]    irq_en,
  input  logic [NUM_CNT-1:0] cnt_flags,
  output logic               dav,
  output logic               lvl_full,
  output logic               lvl_empty,
  output logic               stk_full,
  output logic               stk_empty,
  output logic               irq
);

  logic lf_n, le_n, sf_n, se_n;

  always_comb begin
    if (clr) begin
      lf_n = 1'b0; le_n = 1'b0; sf_n = 1'b0; se_n = 1'b0;
    end else begin
      le_n = evt.wr  ? 1'b0 : (evt.dry ? 1'b1 : lvl_empty);
      lf_n = evt.ovf ? 1'b1 : ((evt.take || evt.dry) ? 1'b0 : lvl_full);
      sf_n = evt.ovf ? 1'b1 : (stat_rd ? 1'b0 : stk_full);
      se_n = evt.dry ? 1'b1 : (stat_rd ? 1'b0 : stk_empty);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_full  <= 1'b0;
      lvl_empty <= 1'b0;
      stk_full  <= 1'b0;
      stk_empty <= 1'b0;
      irq       <= 1'b0;
      dav       <= ~dav_pol;
    end else begin
      lvl_full  <= lf_n;
      lvl_empty <= le_n;
      stk_full  <= sf_n;
      stk_empty <= se_n;
      irq       <= |(irq_en & {cnt_flags, se_n, sf_n});
      dav       <= nonempty_n ? dav_pol : ~dav_pol;
    end
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stk_full && !stat_rd && !clr) |=> stk_full); // R8

  AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (evt.wr && !clr) |=> !lvl_empty); // R6

endmodule

// File: rtl/conv_fifo.sv
module conv_fifo
  import conv_fifo_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int NUM_CONV = 3,
  parameter int TAG_W    = 4,
  parameter int RES_W    = 12,
  parameter int NUM_CNT  = 2,
  localparam int WORD_W  = TAG_W + RES_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      conv_valid,
  input  logic [NUM_CONV*TAG_W-1:0] conv_tag,
  input  logic [NUM_CONV*RES_W-1:0] conv_res,
  input  logic                      rd_en,
  input  logic                      stat_rd,
  input  logic                      dav_pol,
  input  logic [NUM_CNT+1:0]        irq_en,
  input  logic [NUM_CNT-1:0]        cnt_flags,
  output logic [WORD_W-1:0]         rd_data,
  output logic                      dav,
  output logic                      lvl_full,
  output logic                      lvl_empty,
  output logic                      stk_full,
  output logic                      stk_empty,
  output logic                      irq
);

  logic              wr_en;
  logic [WORD_W-1:0] wr_word;
  logic              nonempty_n;
  fifo_evt_t         evt;

  cf_serializer #(.NUM_CONV(NUM_CONV), .TAG_W(TAG_W), .RES_W(RES_W)) u_ser (
    .clk(clk), .rst(rst), .clr(clr),
    .conv_valid(conv_valid), .conv_tag(conv_tag), .conv_res(conv_res),
    .wr_en(wr_en), .wr_word(wr_word)
  );

  cf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst(rst), .clr(clr),
    .wr_en(wr_en), .wr_word(wr_word), .rd_en(rd_en),
    .rd_data(rd_data), .nonempty_n(nonempty_n), .evt(evt)
  );

  cf_flags #(.NUM_CNT(NUM_CNT)) u_flags (
    .clk(clk), .rst(rst), .clr(clr), .evt(evt), .nonempty_n(nonempty_n),
    .stat_rd(stat_rd), .dav_pol(dav_pol), .irq_en(irq_en), .cnt_flags(cnt_flags),
    .dav(dav), .lvl_full(lvl_full), .lvl_empty(lvl_empty),
    .stk_full(stk_full), .stk_empty(stk_empty), .irq(irq)
  );

endmodule

// File: tb/conv_fifo_tb_top.sv
module conv_fifo_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int NC = 3;

  logic        clk = 1'b0;
  logic        rst, clr, conv_valid, rd_en, stat_rd, dav_pol;
  logic [11:0] conv_tag;
  logic [35:0] conv_res;
  logic [3:0]  irq_en;
  logic [1:0]  cnt_flags;
  logic [15:0] rd_data;
  logic        dav, lvl_full, lvl_empty, stk_full, stk_empty, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_fifo dut_i (
    .clk(clk), .rst(rst), .clr(clr), .conv_valid(conv_valid),
    .conv_tag(conv_tag), .conv_res(conv_res), .rd_en(rd_en), .stat_rd(stat_rd),
    .dav_pol(dav_pol), .irq_en(irq_en), .cnt_flags(cnt_flags),
    .rd_data(rd_data), .dav(dav), .lvl_full(lvl_full), .lvl_empty(lvl_empty),
    .stk_full(stk_full), .stk_empty(stk_empty), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [15:0] q[$];
  logic [15:0] pend[$];
  logic [15:0] m_last;
  logic m_lf, m_le, m_sf, m_se, m_dav, m_irq;

  always @(posedge clk) begin
    logic [15:0] w;
    bit have_w, take, dry, ovf;
    int n;
    if (rst) begin
      q.delete(); pend.delete();
      m_last = 0; m_lf = 0; m_le = 0; m_sf = 0; m_se = 0; m_irq = 0;
      m_dav = !dav_pol;
    end else if (clr) begin
      q.delete(); pend.delete();
      m_lf = 0; m_le = 0; m_sf = 0; m_se = 0;
      m_dav = !dav_pol;
      m_irq = |(irq_en & {cnt_flags, 2'b00});
    end else begin
      have_w = 0; w = '0;
      if (conv_valid) begin
        w = {conv_tag[3:0], conv_res[11:0]}; have_w = 1;
        pend.delete();
        for (int i = 1; i < NC; i++) pend.push_back({conv_tag[i*4 +: 4], conv_res[i*12 +: 12]});
      end else if (pend.size() > 0) begin
        w = pend.pop_front(); have_w = 1;
      end
      n = q.size();
      take = rd_en && n > 0;
      dry  = rd_en && n == 0;
      ovf  = have_w && n == DEPTH && !rd_en;
      if (take) m_last = q.pop_front();
      if (have_w) begin
        if (ovf) void'(q.pop_front());
        q.push_back(w);
      end
      m_le = have_w ? 1'b0 : (dry ? 1'b1 : m_le);
      m_lf = ovf ? 1'b1 : (rd_en ? 1'b0 : m_lf);
      m_sf = ovf ? 1'b1 : (stat_rd ? 1'b0 : m_sf);
      m_se = dry ? 1'b1 : (stat_rd ? 1'b0 : m_se);
      m_dav = (q.size() != 0) ? dav_pol : !dav_pol;
      m_irq = |(irq_en & {cnt_flags, m_se, m_sf});
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(rd_data === m_last, "R4", "rd_data", rd_data, m_last);
      chk(dav === m_dav, "R3", "dav", dav, m_dav);
      chk(lvl_full === m_lf, "R7", "lvl_full", lvl_full, m_lf);
      chk(lvl_empty === m_le, "R5", "lvl_empty", lvl_empty, m_le);
      chk(stk_full === m_sf, "R8", "stk_full", stk_full, m_sf);
      chk(stk_empty === m_se, "R8", "stk_empty", stk_empty, m_se);
      chk(irq === m_irq, "R9", "irq", irq, m_irq);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic conv(input bit fixed_tags);
    conv_valid = 1;
    for (int i = 0; i < NC; i++) begin
      conv_tag[i*4 +: 4]  = fixed_tags ? 4'(i + 1) : 4'($urandom);
      conv_res[i*12 +: 12] = 12'($urandom);
    end
    tick();
    conv_valid = 0;
    tick(); tick();
  endtask

  task automatic rd();
    rd_en = 1; tick(); rd_en = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog (all requirements): run not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int gap;
    rst = 1; clr = 0; conv_valid = 0; rd_en = 0; stat_rd = 0; dav_pol = 1;
    conv_tag = '0; conv_res = '0; irq_en = 4'hF; cnt_flags = 2'b00;
    repeat (3) tick();
    rst = 0;
    tick();
    // R11 reset state
    chk(rd_data === 16'h0, "R11", "reset rd_data", rd_data, 0);
    chk({lvl_full, lvl_empty, stk_full, stk_empty, irq} === 5'b0, "R11", "reset flags",
        {lvl_full, lvl_empty, stk_full, stk_empty, irq}, 0);
    chk(dav === 1'b0, "R11", "reset dav", dav, 0);

    // R5 read of empty store
    rd();
    chk(lvl_empty === 1'b1, "R5", "empty read sets level", lvl_empty, 1);
    chk(rd_data === 16'h0, "R5", "empty read keeps data", rd_data, 0);
    chk(irq === 1'b1, "R9", "irq from sticky empty", irq, 1);
    stat_rd = 1; tick(); stat_rd = 0;
    chk(stk_empty === 1'b0, "R8", "status read clears sticky", stk_empty, 0);
    chk(lvl_empty === 1'b1, "R8", "level empty unaffected by status read", lvl_empty, 1);

    // R2 order of converter words, R6 write clears empty
    conv(1);
    chk(lvl_empty === 1'b0, "R6", "write clears level empty", lvl_empty, 0);
    conv(1);
    for (int k = 0; k < 2 * NC; k++) begin
      rd();
      chk(rd_data[15:12] === 4'((k % NC) + 1), "R2", "converter order tag",
          rd_data[15:12], (k % NC) + 1);
    end
    chk(dav === 1'b0, "R3", "dav inactive when drained", dav, 0);

    // R7 overwrite: 12 conversions = 36 words, no reads
    for (int k = 0; k < 12; k++) conv(0);
    chk(lvl_full === 1'b1, "R7", "overflow sets level full", lvl_full, 1);
    chk(stk_full === 1'b1, "R8", "overflow sets sticky full", stk_full, 1);
    rd();
    chk(lvl_full === 1'b0, "R7", "read clears level full", lvl_full, 0);
    chk(stk_full === 1'b1, "R8", "sticky full held after read", stk_full, 1);
    for (int k = 0; k < DEPTH - 1; k++) rd();
    chk(dav === 1'b0, "R1", "32 words held, then drained", dav, 0);

    // R3 polarity flip
    dav_pol = 0; tick();
    chk(dav === 1'b1, "R3", "inverted dav when empty", dav, 1);
    conv(0);
    chk(dav === 1'b0, "R3", "inverted dav when data", dav, 0);

    // R9 counter flag sources
    stat_rd = 1; tick(); stat_rd = 0;
    irq_en = 4'b0100; cnt_flags = 2'b10; tick();
    chk(irq === 1'b0, "R9", "disabled counter flag", irq, 0);
    cnt_flags = 2'b01; tick();
    chk(irq === 1'b1, "R9", "enabled counter flag", irq, 1);
    cnt_flags = 2'b00; irq_en = 4'hF; tick();

    // R10 clear in the middle of a conversion cycle
    conv_valid = 1; tick(); conv_valid = 0;
    clr = 1; tick(); clr = 0;
    tick(); tick();
    chk(dav === 1'b1, "R10", "clear leaves store empty (inverted dav)", dav, 1);
    rd();
    chk(lvl_empty === 1'b1, "R10", "pending words dropped by clear", lvl_empty, 1);

    // randomized mix
    gap = 0;
    for (int c = 0; c < 4000; c++) begin
      conv_valid = 0;
      if (gap == 0 && ($urandom % 3) == 0) begin
        conv_valid = 1;
        for (int i = 0; i < NC; i++) begin
          conv_tag[i*4 +: 4]  = 4'($urandom);
          conv_res[i*12 +: 12] = 12'($urandom);
        end
        gap = NC - 1;
      end else if (gap > 0) begin
        gap--;
      end
      rd_en     = (($urandom % 4) == 0);
      stat_rd   = (($urandom % 16) == 0);
      cnt_flags = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      if (($urandom % 64) == 0) irq_en = 4'($urandom);
      if (($urandom % 200) == 0) dav_pol = ~dav_pol;
      clr = (($urandom % 500) == 0);
      if (clr) gap = 0;
      tick();
    end
    conv_valid = 0; rd_en = 0; stat_rd = 0; clr = 0;
    tick();
    done = 1;
    summary();
    $finish;
  end

endmodule